// File: doc/BRIEF.md
# Burst Next-Beat Address Generator

This block works out the address of the following beat of a memory-mapped burst. It is purely combinational. It takes four inputs: the address of the beat now in flight, the bytes-per-beat code, the burst kind and the beat count minus one. From these it returns the address that the next data transfer will use. A transfer engine places it between its beat counter and its address register, and loads the result on every accepted beat.

Three burst kinds are supported. A held burst keeps hitting the same location. A stepping burst walks up through memory one beat at a time. A looping burst walks up inside a window aligned to its own size and returns to the start of that window after the last byte. Both the address width and the data bus width are parameters. The beat-size code is never larger than the bus word allows.

Top module: `burst_next_addr`

## Requirements
- R1: When `burst_kind` is 2'b00 (held), `next_addr` equals `cur_addr` for every size, length and address.
- R2: When `burst_kind` is 2'b01 (stepping), `next_addr` is `cur_addr` rounded down to a multiple of 2^`beat_size` bytes, plus 2^`beat_size`.
- R3: A stepping burst that starts on an address that is not a multiple of the beat size produces the next beat-aligned address, not `cur_addr` + 2^`beat_size`.
- R4: For a stepping burst that stays inside its 4096-byte page, `next_addr` bits 12 and above equal those of `cur_addr`.
- R5: When `burst_kind` is 2'b10 (looping), `next_addr` bits above the window are copied from `cur_addr`. The window is (`beat_len`+1) × 2^`beat_size` bytes.
- R6: For a looping burst, the offset of `next_addr` within the window is (offset of `cur_addr` rounded down to the beat size + 2^`beat_size`) modulo the window size. The last beat of the window therefore returns to the window start.
- R7: Looping bursts give the correct result for every allowed `beat_len` (1, 3, 7, 15) combined with every allowed `beat_size`.
- R8: For stepping and looping bursts, `next_addr` is always a multiple of 2^`beat_size`.
- R9: The block gives correct results for a data bus wider than the default (64 bits), including 8-byte beats, with an address width other than the default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_addr | input | AW | Byte address of the current beat |
| beat_size | input | 3 | Bytes per beat as 2^value, never above log2(DW/8) |
| burst_kind | input | 2 | 00 held, 01 stepping, 10 looping, 11 never driven |
| beat_len | input | 8 | Beats in the burst minus one; only 1, 3, 7 or 15 for looping |
| next_addr | output | AW | Byte address of the following beat |

## Verification
The hardest case to reach is the looping wrap-around. It happens only when the current address sits on the last beat of a window whose size comes from both the length and the size codes, and it must coincide with a narrow beat on a word-aligned address. The directed tests pick addresses by hand that land on the final beat of each window size. A sweep then covers every legal size and length pairing over a range of word-aligned addresses. A second instance with a 64-bit bus and a 16-bit address repeats the wrap and step cases with 8-byte beats.

// File: rtl/burst_next_addr_pkg.sv
// Shared encodings for the next-beat address generator.
package burst_next_addr_pkg;
    // Burst kind code as presented on the burst_kind input.
    typedef enum logic [1:0] {
        BURST_HOLD = 2'b00,
        BURST_STEP = 2'b01,
        BURST_LOOP = 2'b10,
        BURST_RSVD = 2'b11
    } burst_kind_e;
endpackage

// File: rtl/bna_step_dec.sv
// Decodes the beat-size code into a byte step and a mask of the
// sub-beat address bits. Assumes the code is at most log2(DW/8);
// a larger code is clamped to the bus word size.
module bna_step_dec #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [2:0]    size_code,
    output logic [AW-1:0] step,
    output logic [AW-1:0] low_mask
);
    localparam int WORD_LG = $clog2(DW / 8);
    localparam logic [2:0] MAX_CODE = 3'(WORD_LG);

    logic [2:0] eff_code;

    // Clamp the size code to the widest beat the bus carries.
    always_comb begin
        eff_code = (size_code > MAX_CODE) ? MAX_CODE : size_code;
    end

    // Form the step and the mask of the bytes inside one beat.
    always_comb begin
        step     = AW'(1) << eff_code;
        low_mask = step - AW'(1);
    end
endmodule

// File: rtl/bna_wrap_mask.sv
// Builds the mask of the address bits inside a looping window of
// (len+1) beats. Assumes len+1 is a power of two, so the mask is
// len shifted by the size code, ORed with the sub-beat mask.
module bna_wrap_mask #(
    parameter int AW = 32
) (
    input  logic [7:0]    len,
    input  logic [2:0]    size_code,
    input  logic [AW-1:0] low_mask,
    output logic [AW-1:0] win_mask
);
    // Shift the length into place and fill in the bits below one beat.
    always_comb begin
        win_mask = (AW'(len) << size_code) | low_mask;
    end
endmodule

// File: rtl/burst_next_addr.sv
// Top of the next-beat address generator. Purely combinational.
// Assumes legal inputs: no reserved kind, size within the bus word,
// looping lengths of 1/3/7/15 on word-aligned addresses, and
// stepping bursts that stay inside a 4096-byte page.
module burst_next_addr #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [2:0]    beat_size,
    input  logic [1:0]    burst_kind,
    input  logic [7:0]    beat_len,
    output logic [AW-1:0] next_addr
);
    import burst_next_addr_pkg::*;

    logic [AW-1:0] step;
    logic [AW-1:0] low_mask;
    logic [AW-1:0] win_mask;
    logic [AW-1:0] base;
    logic [AW-1:0] bumped;
    burst_kind_e   kind;

    bna_step_dec #(.AW(AW), .DW(DW)) u_step (
        .size_code (beat_size),
        .step      (step),
        .low_mask  (low_mask)
    );

    bna_wrap_mask #(.AW(AW)) u_wrap (
        .len       (beat_len),
        .size_code (beat_size),
        .low_mask  (low_mask),
        .win_mask  (win_mask)
    );

    // Align the current address down to the beat and add one step.
    always_comb begin
        base   = cur_addr & ~low_mask;
        bumped = base + step;
    end

    // Choose the result according to the burst kind.
    always_comb begin
        kind = burst_kind_e'(burst_kind);
        unique case (kind)
            BURST_STEP: next_addr = bumped;
            BURST_LOOP: next_addr = (cur_addr & ~win_mask) | (bumped & win_mask);
            default:    next_addr = cur_addr;
        endcase
    end
endmodule

// File: rtl/burst_next_addr_chk.sv
// Checker for burst_next_addr. It recomputes nothing bit for bit;
// it checks properties of the output for legal inputs only.
module burst_next_addr_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic [AW-1:0] cur_addr,
    input logic [2:0]    beat_size,
    input logic [1:0]    burst_kind,
    input logic [7:0]    beat_len,
    input logic [AW-1:0] next_addr
);
    localparam int WORD_LG = $clog2(DW / 8);

    logic [AW-1:0] beat_bytes;
    logic [AW-1:0] sub_mask;
    logic [AW-1:0] window_mask;
    logic          size_ok;
    logic          in_page;
    logic          len_ok;

    // Derive beat and window geometry arithmetically.
    always_comb begin
        beat_bytes  = AW'(1) << beat_size;
        sub_mask    = beat_bytes - AW'(1);
        window_mask = (AW'(beat_len) + AW'(1)) * beat_bytes - AW'(1);
        size_ok     = (int'(beat_size) <= WORD_LG);
        in_page     = ((cur_addr[11:0] | sub_mask[11:0]) != 12'hFFF);
        len_ok      = (beat_len == 8'd1) || (beat_len == 8'd3) ||
                      (beat_len == 8'd7) || (beat_len == 8'd15);
    end

    // Property checks on the combinational result.
    always_comb begin
        if (burst_kind == 2'b00)
            assert_hold_same_R1: assert (next_addr == cur_addr);
        if (burst_kind == 2'b01 && size_ok && in_page)
            assert_step_forward_R2: assert ((next_addr - (cur_addr & ~sub_mask)) == beat_bytes);
        if (burst_kind == 2'b10 && size_ok && len_ok)
            assert_window_upper_R5: assert ((next_addr & ~window_mask) == (cur_addr & ~window_mask));
        if ((burst_kind == 2'b01 || burst_kind == 2'b10) && size_ok)
            assert_beat_aligned_R8: assert ((next_addr & sub_mask) == '0);
    end

    generate
        if (AW > 12) begin : g_page
            // Page bits stay put for a stepping burst inside its page.
            always_comb begin
                if (burst_kind == 2'b01 && size_ok && in_page)
                    assert_page_kept_R4: assert (next_addr[AW-1:12] == cur_addr[AW-1:12]);
            end
        end
    endgenerate
endmodule

bind burst_next_addr burst_next_addr_chk #(.AW(AW), .DW(DW)) u_chk (
    .cur_addr   (cur_addr),
    .beat_size  (beat_size),
    .burst_kind (burst_kind),
    .beat_len   (beat_len),
    .next_addr  (next_addr)
);

// File: tb/burst_next_addr_bench.sv
// Directed bench for burst_next_addr: one task per scenario.
module burst_next_addr_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fails = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    logic [31:0] a_addr;
    logic [2:0]  a_size;
    logic [1:0]  a_kind;
    logic [7:0]  a_len;
    logic [31:0] a_next;

    logic [15:0] b_addr;
    logic [2:0]  b_size;
    logic [1:0]  b_kind;
    logic [7:0]  b_len;
    logic [15:0] b_next;

    burst_next_addr #(.AW(32), .DW(32)) u_burst_next_addr (
        .cur_addr(a_addr), .beat_size(a_size), .burst_kind(a_kind),
        .beat_len(a_len), .next_addr(a_next)
    );

    burst_next_addr #(.AW(16), .DW(64)) u_wide (
        .cur_addr(b_addr), .beat_size(b_size), .burst_kind(b_kind),
        .beat_len(b_len), .next_addr(b_next)
    );

    // Arithmetic reference model written from the requirements.
    function automatic longint model(longint addr, int size, int kind, int len);
        longint step = longint'(1) << size;
        longint win, base, off;
        case (kind)
            1: return (addr / step) * step + step;
            2: begin
                win  = (len + 1) * step;
                base = addr - (addr % win);
                off  = addr % win;
                return base + (((off / step) * step + step) % win);
            end
            default: return addr;
        endcase
    endfunction

    task automatic check_a(string req, logic [31:0] addr, int size, int kind, int len);
        longint exp;
        @(negedge clk);
        a_addr = addr; a_size = 3'(size); a_kind = 2'(kind); a_len = 8'(len);
        #1;
        exp = model(longint'(addr), size, kind, len) & 64'hFFFF_FFFF;
        n_checks++;
        if (longint'(a_next) != exp) begin
            n_fails++;
            $display("FAIL %s: addr=%h size=%0d kind=%0d len=%0d got %h exp %h",
                     req, addr, size, kind, len, a_next, exp);
        end
    endtask

    task automatic check_b(string req, logic [15:0] addr, int size, int kind, int len);
        longint exp;
        @(negedge clk);
        b_addr = addr; b_size = 3'(size); b_kind = 2'(kind); b_len = 8'(len);
        #1;
        exp = model(longint'(addr), size, kind, len) & 64'hFFFF;
        n_checks++;
        if (longint'(b_next) != exp) begin
            n_fails++;
            $display("FAIL %s: addr=%h size=%0d kind=%0d len=%0d got %h exp %h",
                     req, addr, size, kind, len, b_next, exp);
        end
    endtask

    // Known result for all-zero inputs (held kind).
    task automatic t_idle();
        check_a("R1", 32'h0, 0, 0, 0);
    endtask

    // R1: held bursts return the same address.
    task automatic t_hold();
        check_a("R1", 32'h1234_5677, 2, 0, 9);
        check_a("R1", 32'hFFFF_FFFF, 0, 0, 255);
        check_a("R1", 32'h0000_0FFC, 1, 0, 3);
    endtask

    // R2, R3, R4, R8: stepping bursts, aligned, unaligned, near page end.
    task automatic t_step();
        check_a("R2", 32'h0000_1000, 0, 1, 7);
        check_a("R2", 32'h0000_1000, 1, 1, 7);
        check_a("R2", 32'h0000_1000, 2, 1, 7);
        check_a("R3", 32'h0000_2003, 2, 1, 3);
        check_a("R3", 32'h0000_2005, 1, 1, 3);
        check_a("R4", 32'hABCD_EFF8, 2, 1, 0);
        check_a("R8", 32'h0000_3FF9, 2, 1, 0);
    endtask

    // R5, R6: looping bursts, mid-window and at the last beat.
    task automatic t_loop();
        check_a("R6", 32'h0000_100C, 2, 2, 3);
        check_a("R6", 32'h0000_2004, 1, 2, 1);
        check_a("R6", 32'h0000_2008, 1, 2, 1);
        check_a("R6", 32'h0000_030C, 0, 2, 15);
        check_a("R5", 32'h8765_443C, 2, 2, 15);
        check_a("R5", 32'h0000_0418, 2, 2, 7);
    endtask

    // R7: every legal length/size pair over word-aligned addresses.
    task automatic t_loop_sweep();
        for (int s = 0; s <= 2; s++)
            for (int l = 0; l < 4; l++)
                for (int a = 0; a < 128; a += 4)
                    check_a("R7", 32'h0005_5500 + 32'(a), s, (2 << l) - 1 == 1 ? 2 : 2, (2 << l) - 1);
    endtask

    // R2, R8: stepping sweep that stays inside one page.
    task automatic t_step_sweep();
        for (int s = 0; s <= 2; s++)
            for (int a = 0; a < 64; a++)
                check_a("R8", 32'h0000_0F00 + 32'(a), s, 1, 15);
    endtask

    // R9: 64-bit bus with a 16-bit address.
    task automatic t_wide();
        check_b("R9", 16'h0010, 3, 1, 3);
        check_b("R9", 16'h0013, 3, 1, 3);
        check_b("R9", 16'h0138, 3, 2, 7);
        check_b("R9", 16'h0128, 3, 2, 3);
        check_b("R9", 16'h4440, 3, 2, 15);
        check_b("R9", 16'hBEEF, 3, 0, 0);
        for (int s = 0; s <= 3; s++)
            for (int l = 0; l < 4; l++)
                for (int a = 0; a < 128; a += 8)
                    check_b("R9", 16'h0A00 + 16'(a), s, 2, (2 << l) - 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_fails++;
                $display("FAIL watchdog: got %0d cycles exp below 150000", cycles);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        a_addr = '0; a_size = '0; a_kind = '0; a_len = '0;
        b_addr = '0; b_size = '0; b_kind = '0; b_len = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_hold();
        t_step();
        t_loop();
        t_loop_sweep();
        t_step_sweep();
        t_wide();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule